// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects an on-chip host to an external asynchronous static RAM of 64K words by 16 bits. The host posts one request at a time over a valid/ready handshake. A request carries a word address, a direction flag, a write word and a two-bit byte mask. The controller then runs the strobe sequence on the memory pins and returns read data with a single-cycle valid pulse. It accepts the next request only after it is idle again.

All memory strobes are active low: chip enable, output enable, write enable and one enable per byte lane. The data bus is split into an output word, an output enable and an input word, so the pad tristate logic sits outside the block. The phase lengths are set in nanoseconds and converted at elaboration into clock cycles, rounding up. These phases are the access window, the data setup before the write strobe, the write pulse and the read-to-write bus turnaround. The access window gets one extra cycle of margin. With the defaults at a 10 ns clock, a read holds the strobes for 2 cycles and a write runs 1 setup cycle, 1 pulse cycle and 1 recovery cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, every memory strobe (chip, output, write and both byte enables) is high, the data output enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A write updates only the byte lanes whose mask bit is 1. Mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8. The enable of a selected lane is driven low for the whole write.
- R3: A read returns the stored bits in lanes whose mask bit is 1 and zero in lanes whose mask bit is 0, whatever the memory places on those lanes.
- R4: Each accepted read produces exactly one `rsp_valid` pulse, one cycle long. A write produces none.
- R5: `req_ready` is low from the cycle after acceptance until the controller is idle again, and a request presented while `req_ready` is low has no effect on the memory.
- R6: Write enable is low only while chip enable is low and the controller drives the data bus. The write data is driven at least one full cycle before write enable falls.
- R7: Output enable is never low while the controller drives the data bus or while write enable is low.
- R8: After the last cycle with output enable low, the data output enable stays low for the turnaround cycles plus one idle cycle (at least 2 cycles with the defaults).
- R9: Read data is valid exactly ceil(access_ns / clock_ns) + 1 cycles after the accepting clock edge (2 cycles with the defaults).
- R10: While chip enable stays low, the memory address does not change, and it equals the address of the request being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| req_mask | input | DATA_W/8 | Byte lane select, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read word, unselected lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The bench puts junk on the data bus outside the read window and on unselected lanes. A controller that samples early or skips lane masking then returns that junk instead of zero. Partial-mask writes followed by full reads expose a design that writes whole words, because the untouched lane shows the wrong byte. A write issued straight after a read checks the bus turnaround: a design without the turnaround cycle drives the bus while the memory may still be releasing it. A request held up while the controller is busy checks that the request is ignored: a design that latches it anyway corrupts a word that a later read shows.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int ACCESS_NS     = 10,
  parameter int SETUP_NS      = 5,
  parameter int PULSE_NS      = 7,
  parameter int TURN_NS       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);
  localparam int LANES = DATA_W / 8;

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int ACC_CYC   = to_cyc(ACCESS_NS) + 1;
  localparam int SET_CYC   = to_cyc(SETUP_NS);
  localparam int PULSE_CYC = to_cyc(PULSE_NS);
  localparam int TURN_CYC  = to_cyc(TURN_NS);
  localparam int CNT_W     = 8;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WSET, S_WPUL, S_WREC} state_t;

  state_t               state;
  logic [CNT_W-1:0]     cnt, lim;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [LANES-1:0]     mask_q;
  logic [DATA_W-1:0]    lane_bits;
  logic                 last;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g*8 +: 8] = {8{mask_q[g]}};
  end

  always_comb begin
    case (state)
      S_RD:    lim = CNT_W'(ACC_CYC - 1);
      S_TURN:  lim = CNT_W'(TURN_CYC - 1);
      S_WSET:  lim = CNT_W'(SET_CYC - 1);
      S_WPUL:  lim = CNT_W'(PULSE_CYC - 1);
      default: lim = '0;
    endcase
  end

  assign last = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      cnt       <= last ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
            state   <= req_write ? S_WSET : S_RD;
          end
        end
        S_RD: if (last) begin
          rsp_rdata <= mem_dq_in & lane_bits;
          rsp_valid <= 1'b1;
          state     <= S_TURN;
        end
        S_TURN: if (last) state <= S_IDLE;
        S_WSET: if (last) state <= S_WPUL;
        S_WPUL: if (last) state <= S_WREC;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic active;
  assign active     = (state == S_RD) || (state == S_WSET) || (state == S_WPUL) || (state == S_WREC);
  assign req_ready  = (state == S_IDLE);
  assign mem_ce_n   = !active;
  assign mem_oe_n   = (state != S_RD);
  assign mem_we_n   = (state != S_WPUL);
  assign mem_be_n   = active ? ~mask_q : '1;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (state == S_WSET) || (state == S_WPUL) || (state == S_WREC);
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  assert_oe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

  assert_we_context_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

  assert_we_data_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_dq_oe ##1 !mem_dq_oe));

  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = (10 + CLK_PERIOD - 1) / CLK_PERIOD + 1;
  localparam int MIN_GAP    = 3;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_mask = 0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_addr, mem_dq_out;
  logic [15:0] mem_dq_in = 16'hDEAD;

  sram_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_drive = -100, reads_issued = 0, rsp_seen = 0;
  logic [15:0] ext_mem [int];
  logic [15:0] ref_mem [int];
  logic [15:0] exp_data [$];
  int          exp_cyc [$];
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_rd(input int a);
    return ext_mem.exists(a) ? ext_mem[a] : 16'h0000;
  endfunction

  // memory model, protocol watch and response monitor
  always @(negedge clk) if (rst_n) begin
    if (!mem_ce_n && !mem_we_n) begin
      logic [15:0] w;
      w = mem_rd(int'(mem_addr));
      if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
      if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
      ext_mem[int'(mem_addr)] = w;
      if (!mem_dq_oe) check(0, "R6 write without data drive", 0, 1);
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      logic [15:0] r;
      r = mem_rd(int'(mem_addr));
      if (mem_be_n[0]) r[7:0]  = 8'h5A;
      if (mem_be_n[1]) r[15:8] = 8'hA5;
      mem_dq_in <= r;
      last_drive = cyc;
      if (mem_dq_oe) check(0, "R7 bus contention", 1, 0);
    end else begin
      mem_dq_in <= 16'hDEAD;
    end
    if (mem_dq_oe && (cyc - last_drive) < MIN_GAP)
      check(0, "R8 drive too soon after read", cyc - last_drive, MIN_GAP);
    if (rsp_valid) begin
      rsp_seen++;
      if (exp_data.size() == 0) check(0, "R4 unexpected rsp_valid", 1, 0);
      else begin
        logic [15:0] e;
        int c;
        e = exp_data.pop_front();
        c = exp_cyc.pop_front();
        check(rsp_rdata == e, "R3 read data", rsp_rdata, e);
        check(cyc - c == EXP_LAT, "R9 read latency", cyc - c, EXP_LAT);
      end
    end
  end

  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R5 ready low after accept", req_ready, 0);
    if (wr) begin
      logic [15:0] w;
      w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      ref_mem[int'(a)] = w;
      check(mem_addr == a, "R10 address matches request", mem_addr, a);
      check(mem_be_n == ~m, "R2 lane enables", mem_be_n, ~m);
    end else begin
      logic [15:0] e;
      e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
      e = e & {{8{m[1]}}, {8{m[0]}}};
      exp_data.push_back(e);
      exp_cyc.push_back(cyc);
      reads_issued++;
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 1, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid} == 8'b11111010,
          "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid}, 8'b11111010);
    rst_n = 1;
    @(negedge clk);
    check({mem_ce_n, mem_dq_oe, req_ready, rsp_valid} == 4'b1010, "R1 after reset",
          {mem_ce_n, mem_dq_oe, req_ready, rsp_valid}, 4'b1010);

    issue(1, 16'h0010, 16'h1234, 2'b11);
    issue(0, 16'h0010, 16'h0000, 2'b11);
    issue(1, 16'h0010, 16'hABCD, 2'b01);   // R2 low lane only
    issue(0, 16'h0010, 16'h0000, 2'b11);
    issue(1, 16'h0010, 16'hEF99, 2'b10);   // R2 high lane only
    issue(0, 16'h0010, 16'h0000, 2'b11);
    issue(0, 16'h0010, 16'h0000, 2'b01);   // R3 high lane masked off
    issue(0, 16'h0010, 16'h0000, 2'b10);   // R3 low lane masked off
    issue(1, 16'hFFFF, 16'h5555, 2'b11);
    issue(1, 16'h0000, 16'hAAAA, 2'b11);
    issue(0, 16'hFFFF, 16'h0000, 2'b11);
    issue(1, 16'h0000, 16'h0F0F, 2'b00);   // R2 empty mask leaves word intact
    issue(0, 16'h0000, 16'h0000, 2'b11);
    issue(0, 16'h1234, 16'h0000, 2'b11);

    // R5: request while busy is ignored
    issue(0, 16'h0010, 16'h0000, 2'b11);
    req_valid = 1; req_write = 1; req_addr = 16'h0010; req_wdata = 16'h0BAD; req_mask = 2'b11;
    @(negedge clk);
    check(!req_ready, "R5 still busy", req_ready, 0);
    req_valid = 0;
    issue(0, 16'h0010, 16'h0000, 2'b11);

    // R8: write straight after read
    issue(0, 16'hFFFF, 16'h0000, 2'b11);
    issue(1, 16'h0020, 16'hC3C3, 2'b11);
    issue(0, 16'h0020, 16'h0000, 2'b11);

    repeat (10) @(negedge clk);
    check(rsp_seen == reads_issued, "R4 one response per read", rsp_seen, reads_issued);
    check(exp_data.size() == 0, "R4 no missing responses", exp_data.size(), 0);
    done = 1;
    finish_run();
  end
endmodule